// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Window

This block holds a bank of 256 byte-wide configuration registers behind a two-address I/O window. The host first writes a register number to the low address of the window (the index port). It then reads or writes the selected register through the high address (the data port). Reads are combinational. A read returns the byte held before any write in the same cycle.

Two registers hold the base addresses of the serial ports. They are guarded: a write to one of them lands only when it carries that port's single legal value, so software cannot move the ports. A few registers load fixed defaults on reset, and all others clear to zero. The whole window is off after reset. A bit in a bridge configuration byte, written through a separate configuration write port, switches it on and off. While the window is off it ignores every access and reads back all ones.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is disabled, so a data-port read returns 0xFF, and the current index is 0x00.
- R2: The window enable follows bit 1 of a bridge configuration write at offset 0x85. Writes at any other offset leave the enable unchanged, and a write at 0x85 with bit 1 clear disables the window.
- R3: A write to I/O address 0x3F0 (index port) stores the full data byte as the current index, effective from the next cycle. A read in the same cycle still uses the old index.
- R4: A read at 0x3F1 (data port), or at 0x3F0, returns the register selected by the current index in the same cycle.
- R5: After reset the registers hold these values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE.
- R6: Every other register is 0x00 after reset.
- R7: A data-port write to an unguarded index stores the whole byte, and this includes registers that have a reset default. A read in the same cycle returns the previous value.
- R8: A data write to index 0xE7 takes effect only with value 0xFE. Any other value is discarded.
- R9: A data write to index 0xE8 takes effect only with value 0xBE. Any other value is discarded.
- R10: While the window is disabled, reads return 0xFF, and writes change neither the index nor any register.
- R11: An access at an address other than 0x3F0 or 0x3F1 is ignored. Such a read returns 0xFF, and such a write changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Bridge configuration byte write strobe |
| cfg_off | input | 8 | Bridge configuration byte offset |
| cfg_wdata | input | 8 | Bridge configuration write byte |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O byte write strobe |
| io_rd | input | 1 | I/O byte read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte, combinational, 0xFF when not claimed |

## Verification
The assertions assume the following about the inputs:
- Strobes, address and data are known and steady around each rising edge.
- At most one access is presented per cycle. A read and a write may share a cycle.

The stimulus respects these assumptions. Every input changes shortly after a rising edge, one access per cycle, and each strobe is released after one cycle. Read data is compared at the falling edge. At that point the combinational read reflects the state before the coming edge.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int unsigned IO_AW   = 16;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned IDX_W   = 8;
    localparam int unsigned CFG_AW  = 8;

    localparam logic [IO_AW-1:0]  WIN_BASE     = 16'h03F0;
    localparam logic [CFG_AW-1:0] BRIDGE_CTL   = 8'h85;
    localparam int unsigned       WIN_EN_BIT   = 1;

    localparam logic [7:0] SER_A_IDX   = 8'hE7;
    localparam logic [7:0] SER_A_LEGAL = 8'hFE;
    localparam logic [7:0] SER_B_IDX   = 8'hE8;
    localparam logic [7:0] SER_B_LEGAL = 8'hBE;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic rd;
    } sio_acc_t;

    function automatic logic [7:0] reset_value(input logic [7:0] idx);
        case (idx)
            8'hE0:   return 8'h3C;
            8'hE2:   return 8'h03;
            8'hE3:   return 8'hFC;
            8'hE6:   return 8'hDE;
            8'hE7:   return SER_A_LEGAL;
            8'hE8:   return SER_B_LEGAL;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic write_allowed(input logic [7:0] idx,
                                           input logic [7:0] data);
        if (idx == SER_A_IDX) return data == SER_A_LEGAL;
        if (idx == SER_B_IDX) return data == SER_B_LEGAL;
        return 1'b1;
    endfunction

endpackage

// File: rtl/sio_decode.sv
module sio_decode
    import sio_cfg_pkg::*;
#(
    parameter int unsigned         AW   = IO_AW,
    parameter logic [AW-1:0]       BASE = WIN_BASE
) (
    input  logic          win_en,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    output sio_acc_t      acc
);
    logic hit;

    always_comb begin
        hit        = win_en && (io_addr[AW-1:1] == BASE[AW-1:1]);
        acc.idx_wr = hit && io_wr && !io_addr[0];
        acc.dat_wr = hit && io_wr &&  io_addr[0];
        acc.rd     = hit && io_rd;
    end
endmodule

// File: rtl/sio_enable.sv
module sio_enable
    import sio_cfg_pkg::*;
#(
    parameter int unsigned       OW      = CFG_AW,
    parameter int unsigned       DW      = DATA_W,
    parameter logic [OW-1:0]     CTL_OFF = BRIDGE_CTL,
    parameter int unsigned       EN_BIT  = WIN_EN_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [OW-1:0] cfg_off,
    input  logic [DW-1:0] cfg_wdata,
    output logic          win_en
);
    logic unused_cfg;
    assign unused_cfg = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            win_en <= 1'b0;
        else if (cfg_we && cfg_off == CTL_OFF)
            win_en <= cfg_wdata[EN_BIT];
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_off == CTL_OFF) |=> $stable(win_en)); // R2
endmodule

// File: rtl/sio_index.sv
module sio_index
    import sio_cfg_pkg::*;
#(
    parameter int unsigned IW = IDX_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (load)
            idx <= wdata[IW-1:0];
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(idx)); // R3
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> idx == $past(wdata[IW-1:0])); // R3
endmodule

// File: rtl/sio_bank.sv
module sio_bank
    import sio_cfg_pkg::*;
#(
    parameter int unsigned IW = IDX_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned NREG = 1 << IW;

    logic [DW-1:0] regs [NREG];
    logic          accept;

    assign accept = we && write_allowed(8'(idx), 8'(wdata));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= DW'(reset_value(8'(g)));
            else if (accept && idx == IW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[idx];

    AST_SER_A_LOCKED: assert property (@(posedge clk) disable iff (rst)
        regs[SER_A_IDX] == SER_A_LEGAL); // R8
    AST_SER_B_LOCKED: assert property (@(posedge clk) disable iff (rst)
        regs[SER_B_IDX] == SER_B_LEGAL); // R9
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> regs[$past(idx)] == $past(rdata)); // R7
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int unsigned        AW   = IO_AW,
    parameter int unsigned        DW   = DATA_W,
    parameter int unsigned        IW   = IDX_W,
    parameter int unsigned        OW   = CFG_AW,
    parameter logic [AW-1:0]      BASE = WIN_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [OW-1:0] cfg_off,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata
);
    logic          win_en;
    sio_acc_t      acc;
    logic [IW-1:0] idx;
    logic [DW-1:0] bank_rdata;

    sio_enable #(.OW(OW), .DW(DW)) u_enable (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .win_en(win_en)
    );

    sio_decode #(.AW(AW), .BASE(BASE)) u_decode (
        .win_en(win_en), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .acc(acc)
    );

    sio_index #(.IW(IW), .DW(DW)) u_index (
        .clk(clk), .rst(rst), .load(acc.idx_wr), .wdata(io_wdata), .idx(idx)
    );

    sio_bank #(.IW(IW), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .we(acc.dat_wr), .idx(idx),
        .wdata(io_wdata), .rdata(bank_rdata)
    );

    assign io_rdata = acc.rd ? bank_rdata : '1;

    AST_OFF_READS_ONES: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !win_en) |-> io_rdata == '1); // R10
    AST_OFF_IDX_KEPT: assert property (@(posedge clk) disable iff (rst)
        !win_en |=> $stable(idx)); // R10
    AST_OUTSIDE_READ: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr[AW-1:1] != BASE[AW-1:1]) |-> io_rdata == '1); // R11
endmodule

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    sio_cfg_port dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic io_op(input logic [15:0] a, input bit w, input bit r,
                         input logic [7:0] d, input logic [7:0] e,
                         input string tag);
        @(posedge clk); #2;
        cfg_we = 1'b0;
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        if (r) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic cfg_op(input logic [7:0] off, input logic [7:0] d);
        @(posedge clk); #2;
        io_wr = 1'b0; io_rd = 1'b0;
        cfg_we = 1'b1; cfg_off = off; cfg_wdata = d;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        io_wr = 1'b0; io_rd = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] i);
        io_op(16'h03F0, 1'b1, 1'b0, i, 8'h00, "");
    endtask

    task automatic wr_dat(input logic [7:0] d);
        io_op(16'h03F1, 1'b1, 1'b0, d, 8'h00, "");
    endtask

    task automatic rd_dat(input logic [7:0] e, input string tag);
        io_op(16'h03F1, 1'b0, 1'b1, 8'h00, e, tag);
    endtask

    // monitor: scoreboard compare at the falling edge
    always @(negedge clk) begin
        if (!rst && io_rd) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read actual=%02h expected=none", io_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%02h expected=%02h", t, io_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        rd_dat(8'hFF, "R1 disabled after reset");
        // R10: writes while off must not load index or data
        wr_idx(8'hE0);
        wr_dat(8'h55);
        rd_dat(8'hFF, "R10 read while disabled");

        cfg_op(8'h84, 8'hFF);
        rd_dat(8'hFF, "R2 other offset no enable");
        cfg_op(8'h85, 8'hFD);
        rd_dat(8'hFF, "R2 bit1 clear stays off");
        cfg_op(8'h85, 8'h02);
        rd_dat(8'h00, "R1 R10 index zero, reg0 untouched");

        wr_idx(8'hE0); rd_dat(8'h3C, "R5 E0");
        wr_idx(8'hE2); rd_dat(8'h03, "R5 E2");
        wr_idx(8'hE3); rd_dat(8'hFC, "R5 E3");
        wr_idx(8'hE6); rd_dat(8'hDE, "R5 E6");
        wr_idx(8'hE7); rd_dat(8'hFE, "R5 E7");
        wr_idx(8'hE8); rd_dat(8'hBE, "R5 E8");

        wr_idx(8'hE1); rd_dat(8'h00, "R6 E1");
        wr_idx(8'hE4); rd_dat(8'h00, "R6 E4");
        wr_idx(8'hE9); rd_dat(8'h00, "R6 E9");
        wr_idx(8'hFF); rd_dat(8'h00, "R6 FF");
        wr_idx(8'h7F); rd_dat(8'h00, "R6 7F");

        wr_idx(8'h20);
        io_op(16'h03F1, 1'b1, 1'b1, 8'hA5, 8'h00, "R7 same-cycle read old");
        rd_dat(8'hA5, "R7 stored byte");
        wr_idx(8'hE0); wr_dat(8'h11);
        rd_dat(8'h11, "R7 defaulted reg writable");

        io_op(16'h03F0, 1'b0, 1'b1, 8'h00, 8'h11, "R4 read at index port");
        io_op(16'h03F0, 1'b1, 1'b1, 8'h20, 8'h11, "R3 read uses old index");
        rd_dat(8'hA5, "R3 new index in effect");

        wr_idx(8'hE7);
        wr_dat(8'h12); rd_dat(8'hFE, "R8 illegal value dropped");
        wr_dat(8'h00); rd_dat(8'hFE, "R8 zero dropped");
        wr_dat(8'hFE); rd_dat(8'hFE, "R8 legal value");

        wr_idx(8'hE8);
        wr_dat(8'h3E); rd_dat(8'hBE, "R9 illegal value dropped");
        wr_dat(8'hFF); rd_dat(8'hBE, "R9 ones dropped");
        wr_dat(8'hBE); rd_dat(8'hBE, "R9 legal value");

        wr_idx(8'h20);
        io_op(16'h03F2, 1'b1, 1'b0, 8'h77, 8'h00, "");
        io_op(16'h02F1, 1'b1, 1'b0, 8'h66, 8'h00, "");
        io_op(16'h07F0, 1'b1, 1'b0, 8'hE0, 8'h00, "");
        rd_dat(8'hA5, "R11 outside writes ignored");
        io_op(16'h03F2, 1'b0, 1'b1, 8'h00, 8'hFF, "R11 outside read ones");

        cfg_op(8'h85, 8'h00);
        wr_idx(8'h00);
        wr_dat(8'h99);
        rd_dat(8'hFF, "R10 disabled again");
        cfg_op(8'h85, 8'h02);
        rd_dat(8'hA5, "R10 R2 state kept across disable");

        idle();
        repeat (3) @(posedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule